// File: doc/BRIEF.md
# MII Management PHY Register File

This block stands in for the management side of a single 10/100 Ethernet PHY. It holds sixteen 16-bit PHY registers. A MAC-side host reaches them through four host registers: a management address (register number and PHY number), a transmit-data register, a command register and a read-only link-fail status. Every command finishes on the clock edge that accepts it. The read result sits in a read-data register, which drives an output port.

Only PHY number 1 answers. The block keeps the PHY's reset defaults, protects its read-only registers and carries out a self-clearing soft reset through the control register. An external link-up input drives a two-state link machine with states `LNK_DOWN` and `LNK_UP`, moved by the transitions `LINK_RISE` and `LINK_FALL`. On each transition the machine rewrites the link bit of the status register and the link-partner ability register. When scan mode is on, a transition also updates the link-fail bit.

Top module: `mii_mgmt_regfile`

## Requirements
- R1: After reset the PHY registers hold: control (0) = 0x1000, status (1) = 0x7868, identifiers (2, 3) = 0x2000 and 0x5C90, advertisement (4) = 0x01E1, partner (5) = 0x0000, all others zero. The read-data register and the link-fail bit are both 0.
- R2: The host select codes are 0 = management address, 1 = command, 2 = transmit data and 3 = management status. In the address word, bits 12:8 hold the register number and bits 4:0 the PHY number. Command bit 2 writes, bit 1 reads and bit 0 is scan. A read command loads the read-data register on its own edge, and the register holds its value until the next read command.
- R3: A write command to PHY 1 stores the transmit-data register into the selected register. Writing the transmit-data register while PHY 1 is selected writes the new value into the selected register at once, with no command.
- R4: A read command addressed to any PHY other than 1 returns 0xFFFF. Writes to any other PHY change nothing.
- R5: Writes to registers 1, 2 and 3 are ignored. Register numbers 16 to 31 read as 0x0000 and ignore writes.
- R6: A write to register 0 with bit 15 clear stores the value. With bit 15 set, every PHY register returns to its R1 default, with the current link state applied as in R7.
- R7: One clock after the link input rises, status bit 2 is set and the partner register gains bits 0x01E1 by OR. One clock after it falls, status bit 2 clears and the partner register is ANDed with 0x01FF.
- R8: A read command copies the inverse of the link input into the link-fail bit. Host writes to the management status select are ignored.
- R9: Command bit 0 is stored as the scan flag on every command write. While the flag is set, each link transition loads the inverse of the link input into the link-fail bit. While it is clear, transitions leave that bit alone.
- R10: When a host write to the partner register and a link transition land on the same edge, the link rule of R7 is applied on top of the written value. A command with both write and read set returns the value the register held before that edge.
- R11: A soft reset on the same edge as a link rise leaves the defaults with the link-up overlay applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | External link state, 1 = link up |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_sel_i | input | 2 | Host register select (R2 codes) |
| host_wdata_i | input | 16 | Host write data |
| mgmt_rdata_o | output | 16 | Read-data register |
| mgmt_linkfail_o | output | 1 | Link-fail status bit |

## Verification
Host writes and link-machine transitions both write the status and partner registers, and they can meet on one edge. The bench provokes this by changing the link input at the falling edge on which it presents a write to the partner register, and separately a soft reset. A later read then shows whether the link overlay was applied after the host value or after the reset defaults. The bench also uses a combined write-and-read command to check that the read returns the value from before that edge.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int DW = 16;

    // host select codes
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_TXD  = 2'd2,
        SEL_STAT = 2'd3
    } host_sel_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SET_ADDR,
        OP_COMMAND,
        OP_PUSH_DATA,
        OP_STAT_DROP
    } host_op_e;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;

    // command bits
    localparam int CMD_WR   = 2;
    localparam int CMD_RD   = 1;
    localparam int CMD_SCAN = 0;

    // field positions in the address word
    localparam int REG_LSB = 8;
    localparam int PHY_LSB = 0;

    // PHY register numbers
    localparam int REG_CTRL    = 0;
    localparam int REG_STAT    = 1;
    localparam int REG_ID1     = 2;
    localparam int REG_ID2     = 3;
    localparam int REG_ADV     = 4;
    localparam int REG_PARTNER = 5;

    localparam int CTRL_SOFT_RST = 15;
    localparam int STAT_LINK     = 2;

    localparam logic [DW-1:0] CTRL_DEF      = 16'h1000;
    localparam logic [DW-1:0] STAT_DEF      = 16'h7868;
    localparam logic [DW-1:0] ID1_DEF       = 16'h2000;
    localparam logic [DW-1:0] ID2_DEF       = 16'h5C90;
    localparam logic [DW-1:0] ABILITY_BITS  = 16'h01E1;
    localparam logic [DW-1:0] PARTNER_KEEP  = 16'h01FF;

    function automatic logic [DW-1:0] reg_default(int idx);
        case (idx)
            REG_CTRL: return CTRL_DEF;
            REG_STAT: return STAT_DEF;
            REG_ID1:  return ID1_DEF;
            REG_ID2:  return ID2_DEF;
            REG_ADV:  return ABILITY_BITS;
            default:  return '0;
        endcase
    endfunction

    function automatic logic reg_read_only(int idx);
        return (idx == REG_STAT) || (idx == REG_ID1) || (idx == REG_ID2);
    endfunction

    function automatic logic [DW-1:0] link_overlay(int idx, logic [DW-1:0] v, logic up);
        logic [DW-1:0] r;
        r = v;
        if (idx == REG_STAT) begin
            r[STAT_LINK] = up;
        end else if (idx == REG_PARTNER) begin
            r = up ? (v | ABILITY_BITS) : (v & PARTNER_KEEP);
        end
        return r;
    endfunction

endpackage

// File: rtl/mii_link_fsm.sv
module mii_link_fsm
    import mii_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_up_i,
    output logic link_q,
    output logic rise_o,
    output logic fall_o
);

    link_state_e st_q, st_d;

    // next state: LINK_RISE moves DOWN->UP, LINK_FALL moves UP->DOWN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LNK_DOWN: if (link_up_i)  st_d = LNK_UP;
            LNK_UP:   if (!link_up_i) st_d = LNK_DOWN;
            default:  st_d = LNK_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LNK_DOWN;
        else        st_q <= st_d;
    end

    always_comb begin
        link_q = 1'b0;
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (st_q)
            LNK_DOWN: rise_o = link_up_i;
            LNK_UP: begin
                link_q = 1'b1;
                fall_o = !link_up_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
    import mii_mgmt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int REG_AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_we_i,
    input  logic [REG_AW-1:0] phy_waddr_i,
    input  logic [DW-1:0]     phy_wdata_i,
    input  logic [REG_AW-1:0] rd_addr_i,
    input  logic              link_up_i,
    input  logic              link_evt_i,
    output logic [DW-1:0]     rdata_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DW-1:0] rd_vec [NUM_REGS];
    logic          soft_rst;
    logic          overlay;

    assign soft_rst = phy_we_i && (phy_waddr_i == REG_AW'(REG_CTRL))
                      && phy_wdata_i[CTRL_SOFT_RST];
    assign overlay  = soft_rst || link_evt_i;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [DW-1:0] DEF = reg_default(gi);
        localparam bit            RO  = reg_read_only(gi);

        logic [DW-1:0] val_q, val_d;
        logic          hit;

        assign hit = phy_we_i && (phy_waddr_i == REG_AW'(gi)) && !RO;

        always_comb begin
            val_d = val_q;
            if (soft_rst)  val_d = DEF;
            else if (hit)  val_d = phy_wdata_i;
            if (overlay)   val_d = link_overlay(gi, val_d, link_up_i);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= link_overlay(gi, DEF, 1'b0);
            else        val_q <= val_d;
        end

        assign rd_vec[gi] = val_q;
    end

    always_comb begin
        if (int'(rd_addr_i) < NUM_REGS) rdata_o = rd_vec[rd_addr_i[IDX_W-1:0]];
        else                            rdata_o = '0;
    end

endmodule

// File: rtl/mii_host_if.sv
module mii_host_if
    import mii_mgmt_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int PHY_AW   = 5,
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [1:0]        host_sel_i,
    input  logic [DW-1:0]     host_wdata_i,
    input  logic              link_up_i,
    input  logic              link_evt_i,
    input  logic [DW-1:0]     phy_rdata_i,
    output logic              phy_we_o,
    output logic [REG_AW-1:0] reg_addr_o,
    output logic [DW-1:0]     phy_wdata_o,
    output logic [PHY_AW-1:0] phy_addr_o,
    output logic [DW-1:0]     rdata_o,
    output logic              linkfail_o,
    output logic              scan_o
);

    host_op_e          op;
    logic [REG_AW-1:0] reg_addr_q;
    logic [PHY_AW-1:0] phy_addr_q;
    logic [DW-1:0]     txd_q;
    logic [DW-1:0]     rdata_q;
    logic              linkfail_q;
    logic              scan_q;
    logic              phy_match;
    logic              rd_cmd;
    logic              wr_cmd;

    always_comb begin
        op = OP_IDLE;
        if (host_wr_i) begin
            unique case (host_sel_i)
                SEL_ADDR: op = OP_SET_ADDR;
                SEL_CMD:  op = OP_COMMAND;
                SEL_TXD:  op = OP_PUSH_DATA;
                SEL_STAT: op = OP_STAT_DROP;
                default:  op = OP_IDLE;
            endcase
        end
    end

    assign phy_match = (phy_addr_q == PHY_AW'(PHY_ADDR));
    assign rd_cmd    = (op == OP_COMMAND) && host_wdata_i[CMD_RD];
    assign wr_cmd    = (op == OP_COMMAND) && host_wdata_i[CMD_WR];

    // transmit-data pushes go straight through; write commands use the stored word
    assign phy_we_o    = ((op == OP_PUSH_DATA) || wr_cmd) && phy_match;
    assign phy_wdata_o = (op == OP_PUSH_DATA) ? host_wdata_i : txd_q;
    assign reg_addr_o  = reg_addr_q;
    assign phy_addr_o  = phy_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr_q <= '0;
            phy_addr_q <= '0;
            txd_q      <= '0;
            rdata_q    <= '0;
            linkfail_q <= 1'b0;
            scan_q     <= 1'b0;
        end else begin
            if (op == OP_SET_ADDR) begin
                reg_addr_q <= host_wdata_i[REG_LSB +: REG_AW];
                phy_addr_q <= host_wdata_i[PHY_LSB +: PHY_AW];
            end
            if (op == OP_PUSH_DATA) txd_q  <= host_wdata_i;
            if (op == OP_COMMAND)   scan_q <= host_wdata_i[CMD_SCAN];
            if (rd_cmd) begin
                rdata_q    <= phy_match ? phy_rdata_i : '1;
                linkfail_q <= !link_up_i;
            end else if (scan_q && link_evt_i) begin
                linkfail_q <= !link_up_i;
            end
        end
    end

    assign rdata_o    = rdata_q;
    assign linkfail_o = linkfail_q;
    assign scan_o     = scan_q;

endmodule

// File: rtl/mii_mgmt_regfile.sv
module mii_mgmt_regfile
    import mii_mgmt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int REG_AW   = 5,
    parameter int PHY_AW   = 5,
    parameter int PHY_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up_i,
    input  logic          host_wr_i,
    input  logic [1:0]    host_sel_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] mgmt_rdata_o,
    output logic          mgmt_linkfail_o
);

    logic              link_q;
    logic              link_rise;
    logic              link_fall;
    logic              link_evt;
    logic              phy_we;
    logic [REG_AW-1:0] reg_addr;
    logic [DW-1:0]     phy_wdata;
    logic [DW-1:0]     phy_rdata;
    logic [PHY_AW-1:0] phy_addr;
    logic              scan_on;

    assign link_evt = link_rise || link_fall;

    mii_link_fsm u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up_i (link_up_i),
        .link_q    (link_q),
        .rise_o    (link_rise),
        .fall_o    (link_fall)
    );

    mii_host_if #(
        .REG_AW   (REG_AW),
        .PHY_AW   (PHY_AW),
        .PHY_ADDR (PHY_ADDR)
    ) u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr_i),
        .host_sel_i   (host_sel_i),
        .host_wdata_i (host_wdata_i),
        .link_up_i    (link_up_i),
        .link_evt_i   (link_evt),
        .phy_rdata_i  (phy_rdata),
        .phy_we_o     (phy_we),
        .reg_addr_o   (reg_addr),
        .phy_wdata_o  (phy_wdata),
        .phy_addr_o   (phy_addr),
        .rdata_o      (mgmt_rdata_o),
        .linkfail_o   (mgmt_linkfail_o),
        .scan_o       (scan_on)
    );

    mii_phy_regs #(
        .NUM_REGS (NUM_REGS),
        .REG_AW   (REG_AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .phy_we_i    (phy_we),
        .phy_waddr_i (reg_addr),
        .phy_wdata_i (phy_wdata),
        .rd_addr_i   (reg_addr),
        .link_up_i   (link_up_i),
        .link_evt_i  (link_evt),
        .rdata_o     (phy_rdata)
    );

endmodule

// File: rtl/mii_mgmt_checker.sv
module mii_mgmt_checker #(
    parameter int PHY_AW   = 5,
    parameter int PHY_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_up_i,
    input logic              host_wr_i,
    input logic [1:0]        host_sel_i,
    input logic [15:0]       host_wdata_i,
    input logic [15:0]       mgmt_rdata_o,
    input logic              mgmt_linkfail_o,
    input logic              link_q,
    input logic              scan_on,
    input logic [PHY_AW-1:0] phy_addr
);

    logic rd_req;
    logic link_moves;

    assign rd_req     = host_wr_i && (host_sel_i == 2'd1) && host_wdata_i[1];
    assign link_moves = (link_up_i != link_q);

    // R2: read-data register only changes on a read command
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(mgmt_rdata_o));

    // R4: foreign PHY reads all ones
    a_r4_foreign_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (phy_addr != PHY_AW'(PHY_ADDR))) |=> (mgmt_rdata_o == 16'hFFFF));

    // R8: read copies inverse link into link-fail
    a_r8_read_linkfail: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (mgmt_linkfail_o == !$past(link_up_i)));

    // R9: without read or scanned transition, link-fail holds
    a_r9_linkfail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !(scan_on && link_moves)) |=> $stable(mgmt_linkfail_o));

    // R9: scanned transition updates link-fail
    a_r9_scan_track: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_on && link_moves) |=> (mgmt_linkfail_o == !$past(link_up_i)));

endmodule

bind mii_mgmt_regfile mii_mgmt_checker #(
    .PHY_AW   (PHY_AW),
    .PHY_ADDR (PHY_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_up_i       (link_up_i),
    .host_wr_i       (host_wr_i),
    .host_sel_i      (host_sel_i),
    .host_wdata_i    (host_wdata_i),
    .mgmt_rdata_o    (mgmt_rdata_o),
    .mgmt_linkfail_o (mgmt_linkfail_o),
    .link_q          (link_q),
    .scan_on         (scan_on),
    .phy_addr        (phy_addr)
);

// File: tb/tb_mii_mgmt_regfile.sv
module tb_mii_mgmt_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [1:0]  host_sel_i = 2'd0;
    logic [15:0] host_wdata_i = 16'h0;
    logic [15:0] mgmt_rdata_o;
    logic        mgmt_linkfail_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [15:0] v;

    always #2 clk = ~clk;

    mii_mgmt_regfile dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .link_up_i       (link_up_i),
        .host_wr_i       (host_wr_i),
        .host_sel_i      (host_sel_i),
        .host_wdata_i    (host_wdata_i),
        .mgmt_rdata_o    (mgmt_rdata_o),
        .mgmt_linkfail_o (mgmt_linkfail_o)
    );

    // R1 default table: {register number, expected value}, link down
    localparam logic [20:0] DEF_TAB [8] = '{
        {5'd0,  16'h1000}, {5'd1,  16'h7868}, {5'd2,  16'h2000}, {5'd3, 16'h5C90},
        {5'd4,  16'h01E1}, {5'd5,  16'h0000}, {5'd9,  16'h0000}, {5'd15, 16'h0000}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic op(logic [1:0] s, logic [15:0] d);
        host_wr_i = 1'b1; host_sel_i = s; host_wdata_i = d;
        @(negedge clk);
        host_wr_i = 1'b0;
    endtask

    task automatic point(int phy, int rg);
        op(2'd0, 16'((rg << 8) | phy));
    endtask

    task automatic rd(int phy, int rg, output logic [15:0] val);
        point(phy, rg);
        op(2'd1, 16'h0002);
        val = mgmt_rdata_o;
    endtask

    task automatic wr_now(int phy, int rg, logic [15:0] d);
        point(phy, rg);
        op(2'd2, d);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", mgmt_rdata_o, 16'h0);
        chk("R1 linkfail after reset", 16'(mgmt_linkfail_o), 16'h0);

        for (int i = 0; i < 8; i++) begin
            rd(1, int'(DEF_TAB[i][20:16]), v);
            chk("R1 default register", v, DEF_TAB[i][15:0]);
        end
        chk("R8 linkfail after read with link down", 16'(mgmt_linkfail_o), 16'h1);

        // R3 immediate write via transmit data
        wr_now(1, 4, 16'h1234);
        rd(1, 4, v); chk("R3 push write", v, 16'h1234);
        // R4 dropped writes to phy 2
        point(2, 7); op(2'd2, 16'h5555); op(2'd1, 16'h0004);
        // R3 write command to phy 1 uses stored transmit data
        point(1, 6); op(2'd1, 16'h0004);
        rd(1, 6, v); chk("R3 write command", v, 16'h5555);
        rd(1, 7, v); chk("R4 foreign write dropped", v, 16'h0000);
        rd(2, 6, v); chk("R4 foreign read ones", v, 16'hFFFF);

        // R5 read-only and out of range
        wr_now(1, 1, 16'h0000); rd(1, 1, v); chk("R5 status read-only", v, 16'h7868);
        wr_now(1, 3, 16'h0000); rd(1, 3, v); chk("R5 id2 read-only", v, 16'h5C90);
        wr_now(1, 20, 16'h1111); rd(1, 20, v); chk("R5 reg 20 reads zero", v, 16'h0000);

        // R6 control store and soft reset
        wr_now(1, 0, 16'h0100); rd(1, 0, v); chk("R6 control store", v, 16'h0100);
        wr_now(1, 0, 16'h8000);
        rd(1, 0, v); chk("R6 soft reset control", v, 16'h1000);
        rd(1, 4, v); chk("R6 soft reset adv", v, 16'h01E1);
        rd(1, 6, v); chk("R6 soft reset reg6", v, 16'h0000);

        // R8 status select ignored; R9 scan off ignores link rise
        op(2'd3, 16'h0000);
        chk("R8 status write ignored", 16'(mgmt_linkfail_o), 16'h1);
        link_up_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 scan off holds linkfail", 16'(mgmt_linkfail_o), 16'h1);
        rd(1, 1, v); chk("R7 link up status", v, 16'h786C);
        chk("R8 read with link up", 16'(mgmt_linkfail_o), 16'h0);
        rd(1, 5, v); chk("R7 link up partner", v, 16'h01E1);

        // R9 scan on tracks link
        op(2'd1, 16'h0001);
        link_up_i = 1'b0;
        @(negedge clk);
        chk("R9 scan fall", 16'(mgmt_linkfail_o), 16'h1);
        link_up_i = 1'b1;
        @(negedge clk);
        chk("R9 scan rise", 16'(mgmt_linkfail_o), 16'h0);

        // R7 fall masks partner
        wr_now(1, 5, 16'hFFFF); rd(1, 5, v); chk("R7 partner host write", v, 16'hFFFF);
        link_up_i = 1'b0;
        @(negedge clk);
        rd(1, 5, v); chk("R7 link down partner mask", v, 16'h01FF);
        rd(1, 1, v); chk("R7 link down status", v, 16'h7868);

        // R10 same-edge host write and link rise
        point(1, 5);
        link_up_i = 1'b1;
        op(2'd2, 16'h8000);
        rd(1, 5, v); chk("R10 write plus rise", v, 16'h81E1);
        // R10 combined write+read returns prior value
        wr_now(1, 6, 16'h1111);
        point(2, 6); op(2'd2, 16'h7777);
        point(1, 6); op(2'd1, 16'h0006);
        chk("R10 write+read old value", mgmt_rdata_o, 16'h1111);
        rd(1, 6, v); chk("R10 write+read new value", v, 16'h7777);

        // R11 soft reset with link rise on the same edge
        link_up_i = 1'b0;
        @(negedge clk);
        wr_now(1, 5, 16'h0000);
        point(1, 0);
        link_up_i = 1'b1;
        op(2'd2, 16'h8000);
        rd(1, 1, v); chk("R11 status after reset+rise", v, 16'h786C);
        rd(1, 5, v); chk("R11 partner after reset+rise", v, 16'h01E1);
        rd(1, 0, v); chk("R11 control after reset+rise", v, 16'h1000);

        done = 1'b1;
        finish_run();
    end

endmodule